// File: doc/BRIEF.md
# Pixel Stream Packet Deserializer

This block turns a one-bit stream from an image sensor into parallel pixel fields. The stream is sampled once per pixel clock, on the falling edge. Before any pixels arrive, the block locks onto a framing preamble. The preamble is a 16-bit header followed by a frame-open marker bit, then a second copy of the header followed by a line-open marker bit. After the preamble, 12-bit pixel packets arrive back to back with no idle time between them. For each packet the block presents the 8-bit pixel value, a line flag and a frame flag, together with a one-cycle strobe.

A packet whose line flag is 0 is the last packet of its line. A 2-bit end code follows it. This code either closes the line, after which the next line opens with only the second header, or closes the frame, after which the full preamble is needed again. A broken start bit, stop bit, marker or end code raises a one-cycle error pulse and sends the block back to searching for the first header.

Top module: `pix_pkt_deser`

## Requirements
- R1: While `rst_ni` is low, all outputs are 0. After reset is released, the block searches for the first header, so the full two-header preamble is needed before any packet is accepted.
- R2: A header is recognised when the last 16 sampled bits equal 0x1023, with the first bit received as the MSB. Leading junk bits, or a near-miss pattern, only slide the search one bit per cycle and raise no pulse.
- R3: After the first header, the next bit must be 0 (frame open). After the second header, the next bit must be 1 (line open). A marker with the wrong value raises `frm_err_o` for one cycle in the cycle that marker bit is sampled, and returns the block to the first-header search.
- R4: A packet is 12 bits, sent MSB first: a start bit of 1, then pixel bits 7..0, then the line flag, then the frame flag, then a stop bit of 1. `pix_o`, `line_vld_o` and `frame_vld_o` are updated, and `pkt_vld_o` pulses for one cycle, on the edge that samples the stop bit. The fields hold their values at all other times.
- R5: The start bit of a packet may follow the previous stop bit on the very next edge. The block then strobes on each stop bit, exactly 12 cycles apart, and never strobes on any other bit.
- R6: After a packet whose line flag is 0, the next two bits form an end code, sent MSB first. Code 2'b10 pulses `line_end_o` and returns the block to the second-header search, so the next line needs only the second header and the line-open marker.
- R7: End code 2'b11 pulses `frame_end_o` and returns the block to the first-header search. This code may come straight after the packet, or in the two bits right after a 2'b10 code.
- R8: A stop bit of 0 pulses `frm_err_o` in place of `pkt_vld_o`, leaves the output fields unchanged, and returns the block to the first-header search.
- R9: A start bit of 0, where a packet is expected, pulses `frm_err_o` in that same cycle and returns the block to the first-header search.
- R10: End code 2'b00 or 2'b01 pulses `frm_err_o` on its second bit, with no `line_end_o` or `frame_end_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; the stream is sampled on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data, one bit per pixel clock |
| pix_o | output | 8 | Pixel value of the last good packet |
| line_vld_o | output | 1 | Line flag of the last good packet |
| frame_vld_o | output | 1 | Frame flag of the last good packet |
| pkt_vld_o | output | 1 | One-cycle strobe when a good packet completes |
| line_end_o | output | 1 | One-cycle pulse on a line-end code |
| frame_end_o | output | 1 | One-cycle pulse on a frame-end code |
| frm_err_o | output | 1 | One-cycle pulse on any framing violation |

## Verification
The hardest case to reach is a stop bit followed at once by the next start bit. If the block lost a cycle there, the only sign would be a shifted second packet. The stimulus therefore always sends packets with no idle bits between them, and checks the strobe bit by bit, so that a strobe one cycle late or early shows up as a failure. The same care applies to the window just after a line-end code: the next two bits may be either a frame-end code or the opening zeros of the second header. Both continuations are driven from that state.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    ST_HDR1,
    ST_FV_MARK,
    ST_HDR2,
    ST_LV_MARK,
    ST_PKT,
    ST_END_CODE,
    ST_POST_LINE
  } pds_state_e;
endpackage

// File: rtl/pds_shift.sv
module pds_shift #(
  parameter int SR_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sdata_i,
  output logic [SR_W-1:0] win_o
);
  logic [SR_W-2:0] sr_q;

  // window includes the bit being sampled this edge
  assign win_o = {sr_q, sdata_i};

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= win_o[SR_W-2:0];
  end
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int              HDR_W   = 16,
  parameter logic [HDR_W-1:0] HDR_VAL = 16'h1023,
  parameter int              PKT_W   = 12,
  parameter int              CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [HDR_W-1:0] win_i,
  output logic             take_o,
  output logic             pkt_vld_o,
  output logic             line_end_o,
  output logic             frame_end_o,
  output logic             frm_err_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

  pds_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             le_d, fe_d, err_d;
  logic             din, hdr_hit;

  assign din     = win_i[0];
  assign hdr_hit = (win_i == HDR_VAL);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    take_o  = 1'b0;
    le_d    = 1'b0;
    fe_d    = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_HDR1: if (hdr_hit) state_d = ST_FV_MARK;
      ST_FV_MARK: begin
        if (!din) state_d = ST_HDR2;
        else begin err_d = 1'b1; state_d = ST_HDR1; end
      end
      ST_HDR2: if (hdr_hit) state_d = ST_LV_MARK;
      ST_LV_MARK: begin
        cnt_d = '0;
        if (din) state_d = ST_PKT;
        else begin err_d = 1'b1; state_d = ST_HDR1; end
      end
      ST_PKT: begin
        if (cnt_q == '0 && !din) begin
          err_d = 1'b1; state_d = ST_HDR1;
        end else if (cnt_q == LAST) begin
          cnt_d = '0;  // wraps on the stop bit, no dead cycle
          if (din) begin
            take_o  = 1'b1;
            state_d = win_i[2] ? ST_PKT : ST_END_CODE;
          end else begin
            err_d = 1'b1; state_d = ST_HDR1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_END_CODE: begin
        if (cnt_q == '0) cnt_d = CNT_W'(1);
        else begin
          cnt_d = '0;
          unique case (win_i[1:0])
            2'b10:   begin le_d  = 1'b1; state_d = ST_POST_LINE; end
            2'b11:   begin fe_d  = 1'b1; state_d = ST_HDR1; end
            default: begin err_d = 1'b1; state_d = ST_HDR1; end
          endcase
        end
      end
      ST_POST_LINE: begin
        if (cnt_q == '0) cnt_d = CNT_W'(1);
        else begin
          cnt_d = '0;
          if (win_i[1:0] == 2'b11) begin fe_d = 1'b1; state_d = ST_HDR1; end
          else state_d = ST_HDR2;  // bits already in window feed the header search
        end
      end
      default: state_d = ST_HDR1;
    endcase
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HDR1;
      cnt_q       <= '0;
      pkt_vld_o   <= 1'b0;
      line_end_o  <= 1'b0;
      frame_end_o <= 1'b0;
      frm_err_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      pkt_vld_o   <= take_o;
      line_end_o  <= le_d;
      frame_end_o <= fe_d;
      frm_err_o   <= err_d;
    end
  end

  assert_pulse_excl_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $onehot0({pkt_vld_o, line_end_o, frame_end_o, frm_err_o}));
  assert_no_double_strobe_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |=> !pkt_vld_o);
  assert_cnt_range_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PKT) |-> (cnt_q <= LAST));
  assert_err_resync_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    frm_err_o |-> (state_q == ST_HDR1));
  assert_line_end_next_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    line_end_o |-> (state_q == ST_POST_LINE));
  assert_frame_end_next_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> (state_q == ST_HDR1));
endmodule

// File: rtl/pds_fields.sv
module pds_fields #(
  parameter int PIX_W = 8,
  parameter int PKT_W = PIX_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [PKT_W-2:1] pkt_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             line_vld_o,
  output logic             frame_vld_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o       <= '0;
      line_vld_o  <= 1'b0;
      frame_vld_o <= 1'b0;
    end else if (take_i) begin
      pix_o       <= pkt_i[PKT_W-2 -: PIX_W];
      line_vld_o  <= pkt_i[2];
      frame_vld_o <= pkt_i[1];
    end
  end
endmodule

// File: rtl/pix_pkt_deser.sv
module pix_pkt_deser #(
  parameter int              HDR_W   = 16,
  parameter logic [HDR_W-1:0] HDR_VAL = 16'h1023,
  parameter int              PIX_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             line_vld_o,
  output logic             frame_vld_o,
  output logic             pkt_vld_o,
  output logic             line_end_o,
  output logic             frame_end_o,
  output logic             frm_err_o
);
  localparam int PKT_W = PIX_W + 4;
  localparam int SR_W  = (HDR_W > PKT_W) ? HDR_W : PKT_W;
  localparam int CNT_W = $clog2(PKT_W);

  logic [SR_W-1:0] win;
  logic            take;

  pds_shift #(.SR_W(SR_W)) shift_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdata_i(sdata_i), .win_o(win)
  );

  pds_ctrl #(
    .HDR_W(HDR_W), .HDR_VAL(HDR_VAL), .PKT_W(PKT_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_i(win[HDR_W-1:0]), .take_o(take),
    .pkt_vld_o(pkt_vld_o), .line_end_o(line_end_o),
    .frame_end_o(frame_end_o), .frm_err_o(frm_err_o)
  );

  pds_fields #(.PIX_W(PIX_W), .PKT_W(PKT_W)) fields_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .pkt_i(win[PKT_W-2:1]),
    .pix_o(pix_o), .line_vld_o(line_vld_o), .frame_vld_o(frame_vld_o)
  );

  assert_fields_hold_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !pkt_vld_o |-> $stable(pix_o) && $stable(line_vld_o) && $stable(frame_vld_o));
  assert_reset_quiet_R1: assert property (@(negedge clk_i)
    !rst_ni |-> !pkt_vld_o && !frm_err_o && pix_o == '0);
endmodule

// File: tb/pix_pkt_deser_tb_top.sv
module pix_pkt_deser_tb_top;
  localparam logic [15:0] HDR = 16'h1023;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sdata = 1'b0;
  logic [7:0] pix;
  logic       lv, fv, pv, le, fe, err;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pix_pkt_deser dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .pix_o(pix),
    .line_vld_o(lv), .frame_vld_o(fv), .pkt_vld_o(pv),
    .line_end_o(le), .frame_end_o(fe), .frm_err_o(err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive on rising edge, observe after the sampling falling edge
  task automatic send_bit(input bit b);
    @(posedge clk); sdata = b;
    @(negedge clk); #1;
  endtask

  task automatic send_hdr();
    for (int i = 15; i >= 0; i--) send_bit(HDR[i]);
  endtask

  task automatic preamble();
    send_hdr(); send_bit(1'b0); send_hdr(); send_bit(1'b1);
  endtask

  task automatic send_pkt(input string req, input logic [7:0] p, input bit l,
                          input bit f, input bit stop);
    logic [11:0] w;
    int pulses = 0;
    logic [7:0] pix_before;
    w = {1'b1, p, l, f, stop};
    pix_before = pix;
    for (int i = 11; i >= 1; i--) begin
      send_bit(w[i]);
      pulses += int'(pv) + int'(err);
    end
    chk(req, "no pulse before stop", pulses, 0);
    send_bit(w[0]);
    chk(req, "pkt strobe", int'(pv), int'(stop));
    chk(req, "err on stop", int'(err), int'(!stop));
    if (stop) begin
      chk(req, "pixel", int'(pix), int'(p));
      chk(req, "flags", int'({lv, fv}), int'({l, f}));
    end else begin
      chk(req, "pixel held", int'(pix), int'(pix_before));
    end
  endtask

  task automatic send_code(input string req, input logic [1:0] c,
                           input bit exp_le, input bit exp_fe, input bit exp_err);
    send_bit(c[1]);
    chk(req, "no pulse on code bit 1", int'(le) + int'(fe) + int'(err), 0);
    send_bit(c[0]);
    chk(req, "line_end", int'(le), int'(exp_le));
    chk(req, "frame_end", int'(fe), int'(exp_fe));
    chk(req, "err on code", int'(err), int'(exp_err));
  endtask

  // in first-header search, header then 1 gives a marker error
  task automatic probe_hdr1(input string req);
    send_hdr(); send_bit(1'b1);
    chk(req, "first-header search active", int'(err), 1);
  endtask

  task automatic t_reset();
    chk("R1", "outputs in reset", int'({pix, lv, fv, pv, le, fe, err}), 0);
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic t_frame();
    preamble();
    send_pkt("R4", 8'h55, 1'b1, 1'b1, 1'b1);
    send_pkt("R5", 8'hA3, 1'b0, 1'b1, 1'b1);
    send_code("R6", 2'b10, 1'b1, 1'b0, 1'b0);
    send_code("R7", 2'b11, 1'b0, 1'b1, 1'b0);
    probe_hdr1("R7");
  endtask

  task automatic t_multi_line();
    preamble();
    send_pkt("R4", 8'h0F, 1'b0, 1'b1, 1'b1);
    send_code("R6", 2'b10, 1'b1, 1'b0, 1'b0);
    send_hdr(); send_bit(1'b1);
    chk("R6", "no err on line reopen", int'(err), 0);
    send_pkt("R6", 8'hF0, 1'b1, 1'b1, 1'b1);
    send_pkt("R5", 8'h81, 1'b0, 1'b0, 1'b1);
    send_code("R7", 2'b11, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_slide();
    int pulses = 0;
    logic [15:0] near = 16'h1022;
    foreach (near[i]) begin end
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    for (int i = 15; i >= 0; i--) begin
      send_bit(near[i]); pulses += int'(err);
    end
    send_bit(1'b1);
    pulses += int'(err);
    chk("R2", "near-miss header ignored", pulses, 0);
    preamble();
    send_pkt("R2", 8'h6B, 1'b0, 1'b1, 1'b1);
    send_code("R7", 2'b11, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_bad_marker();
    send_hdr(); send_bit(1'b0); send_hdr(); send_bit(1'b0);
    chk("R3", "line marker wrong", int'(err), 1);
    probe_hdr1("R3");
  endtask

  task automatic t_bad_stop();
    preamble();
    send_pkt("R4", 8'h3C, 1'b1, 1'b1, 1'b1);
    send_pkt("R8", 8'hC3, 1'b1, 1'b0, 1'b0);
    probe_hdr1("R8");
  endtask

  task automatic t_bad_start();
    preamble();
    send_bit(1'b0);
    chk("R9", "err on start 0", int'(err), 1);
    probe_hdr1("R9");
  endtask

  task automatic t_bad_code();
    preamble();
    send_pkt("R4", 8'h11, 1'b0, 1'b1, 1'b1);
    send_code("R10", 2'b01, 1'b0, 1'b0, 1'b1);
    probe_hdr1("R10");
  endtask

  task automatic t_reset_mid();
    preamble();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    @(posedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R1", "outputs after mid reset", int'({pix, lv, fv, pv, le, fe, err}), 0);
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    probe_hdr1("R1");
  endtask

  initial begin
    t_reset();
    t_frame();
    t_multi_line();
    t_slide();
    t_bad_marker();
    t_bad_stop();
    t_bad_start();
    t_bad_code();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule